// File: doc/BRIEF.md
# Tagged Accumulator Result Read Controller

This controller serves host reads of accumulation results. It does not return a stored register value. It waits for a live result instead. The host issues a read whose address names an accumulation unit and an operation ID. The controller captures both and watches that unit's result stream. It returns the first result whose tag equals the requested ID as a 64-bit double-precision word.

Up to sixteen accumulation units each present a one-cycle result strobe, a 64-bit value and a 4-bit tag. While a read is waiting, the controller raises a stall line to the addressed unit only. This stops later operations from overwriting the awaited value.

Requests and responses are valid/ready streams, with one read in flight at a time:
- `rq_ready` is high only when no read is pending and no response is held. A request is taken on a cycle where `rq_valid` and `rq_ready` are both high.
- Once `rs_valid` rises, it stays high and `rs_data` stays fixed until the host raises `rs_ready`.
- The stall outputs and result inputs are plain signals without handshake.

Top module: `tagged_result_reader`

## Requirements
- R1: After reset, `rs_valid` is low, every `unit_stall` bit is low and `rq_ready` is high.
- R2: The request address is decoded with the operation ID in bits [3:0] and the unit index in bits [7:4]. Address bits above bit 7 have no effect on which result is returned.
- R3: Only a result strobe from the addressed unit whose tag equals the requested ID completes a read. Strobes from other units, or from the addressed unit with another tag, leave `rs_valid` low.
- R4: If the matching result strobe occurs in the same cycle the request is accepted, `rs_valid` is high in the next cycle with that result's data.
- R5: If the matching strobe comes in a later cycle, `rs_valid` rises in the cycle after that strobe, and `rs_data` equals that strobe's data.
- R6: From the cycle after acceptance up to and including the cycle of the matching strobe, `unit_stall` is one-hot on the addressed unit. In all other cycles it is zero.
- R7: `rq_ready` is low while a read is pending or a response is held. A request presented then is ignored and does not change the response that is returned.
- R8: While `rs_valid` is high and `rs_ready` is low, `rs_valid` stays high and `rs_data` stays unchanged.
- R9: The cycle after the response handshake (`rs_valid` and `rs_ready` both high), `rs_valid` is low and `rq_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Controller can accept a request |
| rq_addr | input | 16 | Read address: {ignored, unit[3:0], id[3:0]} |
| rs_valid | output | 1 | Read response valid |
| rs_ready | input | 1 | Host accepts the response |
| rs_data | output | 64 | Returned result word |
| res_strobe | input | 16 | Per-unit result strobe |
| res_value | input | 1024 | Per-unit 64-bit results, unit u at [64u+63:64u] |
| res_tag | input | 64 | Per-unit 4-bit tags, unit u at [4u+3:4u] |
| unit_stall | output | 16 | Per-unit stall, at most one bit high |

## Verification
A matching result that arrives in the acceptance cycle produces a response one clock later. A later match also produces a response one clock after its strobe. The stall is visible one clock after acceptance, and `rq_ready` returns one clock after the response handshake. The bench drives inputs and samples outputs on the falling edge. Each falling edge therefore shows the state after exactly one rising edge since the stimulus. Every expectation is checked on the first falling edge where it is due, and on each waiting edge before it. This catches responses that arrive early as well as ones that arrive late.

// File: rtl/acc_rd_pkg.sv
package acc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } rd_state_e;
endpackage

// File: rtl/acc_rd_decode.sv
module acc_rd_decode #(
  parameter int UNIT_W = 4,
  parameter int ID_W   = 4
) (
  input  logic [UNIT_W+ID_W-1:0] low_addr,
  output logic [UNIT_W-1:0]      unit_idx,
  output logic [ID_W-1:0]        op_id
);
  assign op_id    = low_addr[ID_W-1:0];
  assign unit_idx = low_addr[ID_W +: UNIT_W];
endmodule

// File: rtl/acc_rd_lane_sel.sv
module acc_rd_lane_sel #(
  parameter int UNIT_W = 4,
  parameter int ID_W   = 4,
  parameter int DATA_W = 64,
  localparam int NUM_UNITS = 1 << UNIT_W
) (
  input  logic [NUM_UNITS-1:0]        strobe,
  input  logic [NUM_UNITS*DATA_W-1:0] value,
  input  logic [NUM_UNITS*ID_W-1:0]   tag,
  input  logic [UNIT_W-1:0]           sel_unit,
  input  logic [ID_W-1:0]             sel_id,
  output logic                        hit,
  output logic [DATA_W-1:0]           hit_data
);
  logic [DATA_W-1:0] lane_val [NUM_UNITS];
  logic [ID_W-1:0]   lane_tag [NUM_UNITS];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_lane
    assign lane_val[u] = value[u*DATA_W +: DATA_W];
    assign lane_tag[u] = tag[u*ID_W +: ID_W];
  end

  assign hit      = strobe[sel_unit] && (lane_tag[sel_unit] == sel_id);
  assign hit_data = lane_val[sel_unit];
endmodule

// File: rtl/acc_rd_ctrl.sv
module acc_rd_ctrl
  import acc_rd_pkg::*;
#(
  parameter int UNIT_W = 4,
  parameter int ID_W   = 4,
  parameter int DATA_W = 64,
  localparam int NUM_UNITS = 1 << UNIT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rq_valid,
  output logic                 rq_ready,
  input  logic [UNIT_W-1:0]    dec_unit,
  input  logic [ID_W-1:0]      dec_id,
  output logic                 rs_valid,
  input  logic                 rs_ready,
  output logic [DATA_W-1:0]    rs_data,
  output logic [UNIT_W-1:0]    sel_unit,
  output logic [ID_W-1:0]      sel_id,
  input  logic                 hit,
  input  logic [DATA_W-1:0]    hit_data,
  output logic [NUM_UNITS-1:0] unit_stall
);
  rd_state_e         state;
  logic [UNIT_W-1:0] held_unit;
  logic [ID_W-1:0]   held_id;

  assign rq_ready = (state == ST_IDLE);
  assign rs_valid = (state == ST_RESP);
  assign sel_unit = (state == ST_IDLE) ? dec_unit : held_unit;
  assign sel_id   = (state == ST_IDLE) ? dec_id   : held_id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      held_unit <= '0;
      held_id   <= '0;
      rs_data   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (rq_valid) begin
          held_unit <= dec_unit;
          held_id   <= dec_id;
          if (hit) begin
            rs_data <= hit_data;
            state   <= ST_RESP;
          end else begin
            state   <= ST_WAIT;
          end
        end
        ST_WAIT: if (hit) begin
          rs_data <= hit_data;
          state   <= ST_RESP;
        end
        ST_RESP: if (rs_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_stall
    assign unit_stall[u] = (state == ST_WAIT) && (held_unit == UNIT_W'(u));
  end

  // R6
  stall_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_stall));

  // R6
  stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|unit_stall) |-> (!rs_valid && !rq_ready));

  // R5
  rsp_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rs_valid) |-> $past(hit));

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_data)));

  // R9
  ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_ready) |=> (rq_ready && !rs_valid));
endmodule

// File: rtl/tagged_result_reader.sv
module tagged_result_reader #(
  parameter int UNIT_W = 4,
  parameter int ID_W   = 4,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  localparam int NUM_UNITS = 1 << UNIT_W,
  localparam int LOW_W     = UNIT_W + ID_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rq_valid,
  output logic                        rq_ready,
  input  logic [ADDR_W-1:0]           rq_addr,
  output logic                        rs_valid,
  input  logic                        rs_ready,
  output logic [DATA_W-1:0]           rs_data,
  input  logic [NUM_UNITS-1:0]        res_strobe,
  input  logic [NUM_UNITS*DATA_W-1:0] res_value,
  input  logic [NUM_UNITS*ID_W-1:0]   res_tag,
  output logic [NUM_UNITS-1:0]        unit_stall
);
  logic [UNIT_W-1:0] dec_unit, sel_unit;
  logic [ID_W-1:0]   dec_id, sel_id;
  logic              hit;
  logic [DATA_W-1:0] hit_data;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^rq_addr[ADDR_W-1:LOW_W];

  acc_rd_decode #(.UNIT_W(UNIT_W), .ID_W(ID_W)) u_dec (
    .low_addr (rq_addr[LOW_W-1:0]),
    .unit_idx (dec_unit),
    .op_id    (dec_id)
  );

  acc_rd_lane_sel #(.UNIT_W(UNIT_W), .ID_W(ID_W), .DATA_W(DATA_W)) u_sel (
    .strobe   (res_strobe),
    .value    (res_value),
    .tag      (res_tag),
    .sel_unit (sel_unit),
    .sel_id   (sel_id),
    .hit      (hit),
    .hit_data (hit_data)
  );

  acc_rd_ctrl #(.UNIT_W(UNIT_W), .ID_W(ID_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rq_valid   (rq_valid),
    .rq_ready   (rq_ready),
    .dec_unit   (dec_unit),
    .dec_id     (dec_id),
    .rs_valid   (rs_valid),
    .rs_ready   (rs_ready),
    .rs_data    (rs_data),
    .sel_unit   (sel_unit),
    .sel_id     (sel_id),
    .hit        (hit),
    .hit_data   (hit_data),
    .unit_stall (unit_stall)
  );
endmodule

// File: tb/tagged_result_reader_tb.sv
module tagged_result_reader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NU = 16;
  localparam int DW = 64;
  localparam int NV = 6;
  // vector: {addr[15:0], delay[7:0], data[63:0]}; delay 0 = match in accept cycle
  localparam logic [87:0] VEC [NV] = '{
    {16'h0035, 8'd0, 64'h3FF0_0000_0000_0000},
    {16'h0072, 8'd3, 64'h4000_1234_5678_9ABC},
    {16'hAB00, 8'd1, 64'hC008_0000_0000_0001},
    {16'h00FF, 8'd5, 64'h7FEF_FFFF_FFFF_FFFF},
    {16'hFF1A, 8'd0, 64'h0000_0000_0000_0001},
    {16'h0049, 8'd2, 64'hBFF8_0000_0000_0000}
  };

  logic clk = 0, rst_n = 0;
  logic rq_valid = 0, rq_ready, rs_valid, rs_ready = 0;
  logic [15:0] rq_addr = '0;
  logic [DW-1:0] rs_data;
  logic [NU-1:0] res_strobe = '0, unit_stall;
  logic [NU*DW-1:0] res_value = '0;
  logic [NU*4-1:0] res_tag = '0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tagged_result_reader dut_i (
    .clk(clk), .rst_n(rst_n), .rq_valid(rq_valid), .rq_ready(rq_ready),
    .rq_addr(rq_addr), .rs_valid(rs_valid), .rs_ready(rs_ready),
    .rs_data(rs_data), .res_strobe(res_strobe), .res_value(res_value),
    .res_tag(res_tag), .unit_stall(unit_stall)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_res(input int u, input logic [3:0] t, input logic [63:0] d);
    res_strobe[u] = 1'b1;
    res_tag[u*4 +: 4] = t;
    res_value[u*DW +: DW] = d;
  endtask

  task automatic clr_res();
    res_strobe = '0;
  endtask

  task automatic finish_rsp(input logic [63:0] d, input string req);
    // response visible now, host holds off one cycle
    chk(rs_valid && rs_data == d, req, rs_data, d);
    chk(unit_stall == '0, "R6 stall released", 64'(unit_stall), 0);
    chk(!rq_ready, "R7 busy", 64'(rq_ready), 0);
    @(negedge clk);
    chk(rs_valid && rs_data == d, "R8 hold", rs_data, d);
    rs_ready = 1;
    @(negedge clk);
    rs_ready = 0;
    chk(!rs_valid && rq_ready, "R9 ready again", {62'd0, rs_valid, rq_ready}, 64'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rs_valid && unit_stall == '0 && rq_ready, "R1 reset",
        {46'd0, unit_stall, rs_valid, rq_ready}, 64'd1);
    rst_n = 1;
    @(negedge clk);
    chk(!rs_valid && unit_stall == '0 && rq_ready, "R1 after release",
        {46'd0, unit_stall, rs_valid, rq_ready}, 64'd1);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] a = VEC[v][87:72];
      int dly = int'(VEC[v][71:64]);
      logic [63:0] d = VEC[v][63:0];
      int u = int'(a[7:4]);
      logic [3:0] id = a[3:0];
      // R2 decode {unit,id} from bits [7:0], upper bits ignored
      chk(rq_ready, "R7 idle ready", 64'(rq_ready), 1);
      rq_valid = 1; rq_addr = a;
      if (dly == 0) put_res(u, id, d);
      else put_res(u, id ^ 4'h1, ~d);  // R3 same unit wrong tag
      @(negedge clk);
      rq_valid = 0; clr_res();
      if (dly == 0) begin
        finish_rsp(d, "R4 same-cycle match");
      end else begin
        for (int k = 1; k <= dly; k++) begin
          chk(!rs_valid, "R3 no early response", 64'(rs_valid), 0);
          chk(unit_stall == (NU'(1) << u), "R6 stall one-hot",
              64'(unit_stall), 64'(NU'(1) << u));
          if (k == dly) put_res(u, id, d);
          else put_res((u + k) % NU, id, d ^ 64'hFF); // R3 other unit same tag
          @(negedge clk);
          clr_res();
        end
        finish_rsp(d, "R5 later match");
      end
    end

    // R7: request presented while pending is ignored
    rq_valid = 1; rq_addr = 16'h0023;
    @(negedge clk);
    rq_addr = 16'h0044; // keep valid high while busy
    chk(!rq_ready, "R7 not ready while pending", 64'(rq_ready), 0);
    put_res(4, 4'h4, 64'hDEAD); // would satisfy the ignored request
    @(negedge clk);
    clr_res();
    chk(!rs_valid, "R7 ignored request did not complete", 64'(rs_valid), 0);
    rq_valid = 0;
    put_res(2, 4'h3, 64'h1111_2222_3333_4444);
    @(negedge clk);
    clr_res();
    finish_rsp(64'h1111_2222_3333_4444, "R7 first request served");

    // R8/R9: immediate accept of response
    rq_valid = 1; rq_addr = 16'h0010;
    put_res(1, 4'h0, 64'h5A5A);
    rs_ready = 1;
    @(negedge clk);
    rq_valid = 0; clr_res();
    chk(rs_valid && rs_data == 64'h5A5A, "R4 response", rs_data, 64'h5A5A);
    @(negedge clk);
    rs_ready = 0;
    chk(!rs_valid && rq_ready, "R9 immediate handshake",
        {62'd0, rs_valid, rq_ready}, 64'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule